// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block produces a serial test stream, one bit per enabled clock, from a 32-bit shift register. The register moves toward its most significant end on each advance, and the new bit enters at bit 0. The bit that enters is the feedback. The same feedback is the serial output, unless QRSS zero-run suppression overrides it.

Three pattern modes are available, chosen at run time:
- **Pseudorandom:** a polynomial x^n + x^y + 1 with programmable n and y.
- **Repetitive:** an n-bit word is recirculated from a 32-bit seed.
- **QRSS:** a fixed tap pair, with suppression of long zero runs.

A new configuration is captured only on a rising edge of the load strobe while the block is enabled. The same event seeds the register.

A small controller sequences the block through three named states:
- **ST_IDLE:** no configuration has been captured since reset, and nothing is emitted.
- **ST_RUN:** the register advances on every clock-enable.
- **ST_HOLD:** the block has been disabled and the register is frozen.

The controller takes these transitions:
- **IDLE→RUN:** an accepted load.
- **RUN→HOLD:** the enable drops.
- **HOLD→RUN:** the enable returns, or an accepted load arrives.
- **RUN→RUN:** an accepted load reseeds the register while running.

Top module: `patgen_top`

## Requirements
- R1: After synchronous reset the state is ST_IDLE and `dvalid` stays low, even with `en` and `ce` high, until the first accepted load.
- R2: A load is accepted when `load` is 1 in a cycle where it was 0 in the previous cycle and `en` is 1. On acceptance, the configuration fields are captured, the register takes `cfg_seed`, and the state becomes ST_RUN. The first bit of the new pattern appears in the next cycle.
- R3: A rising edge on `load` while `en` is 0 changes nothing, and neither does `load` held high across `en` rising. The previously loaded pattern continues unchanged.
- R4: In ST_RUN with `en` and `ce` both 1, the register shifts toward the MSB with the feedback entering bit 0, and `dvalid` is 1. With `ce` at 0 the register holds, `dvalid` is 0, and `dout` stays at its current value.
- R5: Pseudorandom mode is selected by `cfg_rep`=0 and `cfg_qrss`=0. In this mode the feedback is register bit n XOR register bit y. Bits are counted from 1 at the LSB, n = `cfg_len`+1 and y = `cfg_tap`+1. For example, `cfg_len`=8 with `cfg_tap`=4 yields a sequence of period 511 that contains 256 ones.
- R6: Repetitive mode is selected by `cfg_rep`=1 and `cfg_qrss`=0. In this mode the feedback is register bit n, so the output repeats with period n. Seed 0xFFFFFFFE with `cfg_len`=1 gives 1,0,1,0,…. Seed 0xFFFF0001 with `cfg_len`=15 gives one 1 in every 16 bits.
- R7: With `cfg_qrss`=1 the feedback is bit 17 XOR bit 20, counted from 1, whatever the length, tap and repetitive fields hold.
- R8: In QRSS mode `dout` is forced to 1 whenever register bits 1 to 14 are all zero.
- R9: In pseudorandom and QRSS modes the feedback is forced to 1 whenever register bits 1 to 31 are all zero. Repetitive mode has no such override.
- R10: While `en` is 0 the state is ST_HOLD and nothing is emitted. After `en` returns to 1 there is one quiet cycle, and the pattern then resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; gates load acceptance and output |
| ce | input | 1 | Clock enable for advancing the register |
| load | input | 1 | Load strobe; rising edge captures the configuration |
| cfg_len | input | 5 | Pattern length minus one (n−1) |
| cfg_tap | input | 5 | Feedback tap minus one (y−1) |
| cfg_rep | input | 1 | 1 selects repetitive mode |
| cfg_qrss | input | 1 | 1 selects QRSS mode (overrides cfg_rep) |
| cfg_seed | input | 32 | Register seed applied on an accepted load |
| dout | output | 1 | Serial pattern bit |
| dvalid | output | 1 | High in cycles where dout is a new pattern bit |

## Verification
The assertions check several behaviours on every cycle:
- state transitions on acceptance and on enable changes;
- register freezing when no advance occurs, and seeding;
- shift alignment of the register;
- the QRSS tap pair and the zero-run override;
- the lockup escape.

Only the bench scenarios can show the full-sequence properties. These are the 511-bit period and its ones count, the exact repetitive words, and agreement with an arithmetic model for every (n, y) pair. They also include the case where a load made while disabled leaves the running sequence untouched.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

    localparam int PG_WIDTH = 32;
    localparam int PG_IDX_W = $clog2(PG_WIDTH);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pg_state_t;

    typedef enum logic [1:0] {
        MODE_PRBS = 2'd0,
        MODE_REP  = 2'd1,
        MODE_QRSS = 2'd2
    } pg_mode_t;

    typedef struct packed {
        logic [PG_IDX_W-1:0] len;
        logic [PG_IDX_W-1:0] tap;
        logic                rep;
        logic                qrss;
    } pg_cfg_t;

endpackage

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
    import patgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      ce,
    input  logic      load,
    input  pg_cfg_t   cfg_in,
    output logic      accept,
    output logic      shift,
    output pg_cfg_t   cfg_act,
    output pg_state_t state
);

    logic      load_q;
    pg_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b0;
        end else begin
            load_q <= load;
        end
    end

    assign accept = load & ~load_q & en;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (accept)   state_nxt = ST_RUN;
                else if (!en) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (accept || en) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        shift = 1'b0;
        unique case (state)
            ST_IDLE: shift = 1'b0;
            ST_RUN:  shift = en & ce & ~accept;
            ST_HOLD: shift = 1'b0;
            default: shift = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= '0;
        end else if (accept) begin
            cfg_act <= cfg_in;
        end
    end

    assert_accept_runs_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_RUN));

    assert_cfg_frozen_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cfg_act));

    assert_cfg_frozen_held_R3: assert property (@(posedge clk) disable iff (rst)
        (load_q && load) |=> $stable(cfg_act));

    assert_shift_only_running_R4: assert property (@(posedge clk) disable iff (rst)
        shift |-> (state == ST_RUN && en && ce));

    assert_idle_until_load_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !accept) |=> (state == ST_IDLE));

    assert_disable_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !en) |=> (state == ST_HOLD));

endmodule

// File: rtl/patgen_feedback.sv
module patgen_feedback
    import patgen_pkg::*;
#(
    parameter int WIDTH  = PG_WIDTH,
    parameter int QTAP_A = 17,
    parameter int QTAP_B = 20,
    parameter int ZRUN   = 14
) (
    input  logic [WIDTH-1:0] sr,
    input  pg_cfg_t          cfg,
    output logic             fb,
    output logic             dout
);

    localparam int LOCK_W = WIDTH - 1;

    pg_mode_t mode;
    logic     bit_n;
    logic     bit_y;
    logic     lock;
    logic     zrun;
    logic     raw;

    always_comb begin
        if (cfg.qrss)     mode = MODE_QRSS;
        else if (cfg.rep) mode = MODE_REP;
        else              mode = MODE_PRBS;
    end

    assign bit_n = sr[cfg.len];
    assign bit_y = sr[cfg.tap];
    assign lock  = ~|sr[LOCK_W-1:0];
    assign zrun  = ~|sr[ZRUN-1:0];

    always_comb begin
        raw = 1'b0;
        fb  = 1'b0;
        unique case (mode)
            MODE_PRBS: begin
                raw = bit_n ^ bit_y;
                fb  = lock ? 1'b1 : raw;
            end
            MODE_REP: begin
                raw = bit_n;
                fb  = raw;
            end
            MODE_QRSS: begin
                raw = sr[QTAP_A-1] ^ sr[QTAP_B-1];
                fb  = lock ? 1'b1 : raw;
            end
            default: begin
                raw = 1'b0;
                fb  = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (mode == MODE_QRSS && zrun) dout = 1'b1;
        else                           dout = fb;
    end

endmodule

// File: rtl/patgen_shreg.sv
module patgen_shreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             shift,
    input  logic [WIDTH-1:0] seed,
    input  logic             fb,
    output logic [WIDTH-1:0] sr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (accept) begin
            sr <= seed;
        end else if (shift) begin
            sr <= {sr[WIDTH-2:0], fb};
        end
    end

    assert_seed_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (sr == $past(seed)));

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!accept && !shift) |=> $stable(sr));

    assert_shift_alignment_R4: assert property (@(posedge clk) disable iff (rst)
        shift |=> (sr[WIDTH-1:1] == $past(sr[WIDTH-2:0])));

endmodule

// File: rtl/patgen_top.sv
module patgen_top
    import patgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        ce,
    input  logic        load,
    input  logic [4:0]  cfg_len,
    input  logic [4:0]  cfg_tap,
    input  logic        cfg_rep,
    input  logic        cfg_qrss,
    input  logic [31:0] cfg_seed,
    output logic        dout,
    output logic        dvalid
);

    localparam int WIDTH = PG_WIDTH;

    pg_cfg_t    cfg_in;
    pg_cfg_t    cfg_act;
    pg_state_t  state;
    logic       accept;
    logic       shift;
    logic       fb;
    logic [WIDTH-1:0] sr;

    assign cfg_in = '{len: cfg_len, tap: cfg_tap, rep: cfg_rep, qrss: cfg_qrss};

    patgen_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ce      (ce),
        .load    (load),
        .cfg_in  (cfg_in),
        .accept  (accept),
        .shift   (shift),
        .cfg_act (cfg_act),
        .state   (state)
    );

    patgen_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .shift  (shift),
        .seed   (cfg_seed),
        .fb     (fb),
        .sr     (sr)
    );

    patgen_feedback #(.WIDTH(WIDTH)) u_fb (
        .sr   (sr),
        .cfg  (cfg_act),
        .fb   (fb),
        .dout (dout)
    );

    assign dvalid = shift;

    assert_valid_needs_run_R1: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (state == ST_RUN));

    assert_qrss_zero_run_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.qrss && sr[13:0] == 14'd0) |-> dout);

    assert_lockup_escape_R9: assert property (@(posedge clk) disable iff (rst)
        (shift && !(cfg_act.rep && !cfg_act.qrss) && sr[30:0] == 31'd0) |=> sr[0]);

    assert_qrss_taps_R7: assert property (@(posedge clk) disable iff (rst)
        (shift && cfg_act.qrss && sr[30:0] != 31'd0) |=> (sr[0] == ($past(sr[16]) ^ $past(sr[19]))));

    assert_hold_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !dvalid);

endmodule

// File: tb/patgen_top_tb.sv
module patgen_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        ce = 1'b0;
    logic        load = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [4:0]  cfg_tap = '0;
    logic        cfg_rep = 1'b0;
    logic        cfg_qrss = 1'b0;
    logic [31:0] cfg_seed = '0;
    logic        dout;
    logic        dvalid;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_sr;
    logic [4:0]  m_len, m_tap;
    logic        m_rep, m_qrss;
    logic        bits [0:1199];

    always #10 clk = ~clk;

    patgen_top u_dut (
        .clk(clk), .rst(rst), .en(en), .ce(ce), .load(load),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_rep(cfg_rep),
        .cfg_qrss(cfg_qrss), .cfg_seed(cfg_seed),
        .dout(dout), .dvalid(dvalid)
    );

    function automatic logic m_feed(input logic [31:0] s);
        logic f;
        if (m_qrss)      f = s[16] ^ s[19];
        else if (m_rep)  f = s[m_len];
        else             f = s[m_len] ^ s[m_tap];
        if ((m_qrss || !m_rep) && s[30:0] == 31'd0) f = 1'b1;
        return f;
    endfunction

    function automatic logic m_out(input logic [31:0] s);
        if (m_qrss && s[13:0] == 14'd0) return 1'b1;
        return m_feed(s);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_cfg(input logic [4:0] l, input logic [4:0] t, input logic r,
                            input logic q, input logic [31:0] s);
        @(negedge clk);
        cfg_len = l; cfg_tap = t; cfg_rep = r; cfg_qrss = q; cfg_seed = s;
        en = 1'b1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_len = l; m_tap = t; m_rep = r; m_qrss = q; m_sr = s;
    endtask

    task automatic run_bits(input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            chk(req, dvalid, 1'b1);
            chk(req, dout, m_out(m_sr));
            if (i < 1200) bits[i] = dout;
            m_sr = {m_sr[30:0], m_feed(m_sr)};
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        int ones;
        logic ok;
        // R1: reset state, nothing emitted before first load
        repeat (3) @(negedge clk);
        rst = 1'b0; en = 1'b1; ce = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk("R1", dvalid, 1'b0);
        end

        // R5 / R2: x^9+x^5+1, period 511 and 256 ones
        load_cfg(5'd8, 5'd4, 1'b0, 1'b0, 32'hFFFF_FFFF);
        run_bits(1022, "R5");
        ok = 1'b1; ones = 0;
        for (int i = 0; i < 511; i++) begin
            if (bits[i] !== bits[i+511]) ok = 1'b0;
            if (bits[i] === 1'b1) ones++;
        end
        chk("R5 period 511", ok, 1'b1);
        chk("R5 ones 256", ones == 256, 1'b1);

        // R5: sweep every (n, y) pair against the model
        for (int n = 2; n <= 32; n++) begin
            for (int y = 1; y < n; y++) begin
                load_cfg(5'(n-1), 5'(y-1), 1'b0, 1'b0, 32'h9E37_79B9);
                run_bits(24, "R5 sweep");
            end
        end

        // R6: alternating ones and zeros
        load_cfg(5'd1, 5'd0, 1'b1, 1'b0, 32'hFFFF_FFFE);
        run_bits(64, "R6");
        ok = 1'b1;
        for (int i = 0; i < 64; i++) if (bits[i] !== ((i % 2) == 0)) ok = 1'b0;
        chk("R6 alternating", ok, 1'b1);

        // R6: one in sixteen
        load_cfg(5'd15, 5'd3, 1'b1, 1'b0, 32'hFFFF_0001);
        run_bits(64, "R6");
        ones = 0; ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (bits[i] === 1'b1) ones++;
            if (i >= 16 && bits[i] !== bits[i-16]) ok = 1'b0;
        end
        chk("R6 one in 16", ones == 4, 1'b1);
        chk("R6 period 16", ok, 1'b1);

        // R6: every length repeats with period n
        for (int n = 1; n <= 32; n++) begin
            load_cfg(5'(n-1), 5'd0, 1'b1, 1'b0, 32'hA5C3_96E1);
            run_bits(2*n + 2, "R6 sweep");
            ok = 1'b1;
            for (int i = n; i < 2*n + 2; i++) if (bits[i] !== bits[i-n]) ok = 1'b0;
            chk("R6 repeat", ok, 1'b1);
        end

        // R9: repetitive with all-zero seed is not forced
        load_cfg(5'd7, 5'd0, 1'b1, 1'b0, 32'h0000_0000);
        #1; chk("R9 rep no escape", dout, 1'b0);
        run_bits(8, "R9");

        // R9: pseudorandom lockup escape
        load_cfg(5'd8, 5'd4, 1'b0, 1'b0, 32'h0000_0000);
        #1; chk("R9 zero seed", dout, 1'b1);
        run_bits(40, "R9");
        load_cfg(5'd4, 5'd2, 1'b0, 1'b0, 32'h8000_0000);
        #1; chk("R9 msb only", dout, 1'b1);
        run_bits(40, "R9");

        // R7: QRSS taps regardless of length/tap
        load_cfg(5'd3, 5'd1, 1'b1, 1'b1, 32'h0001_0001);
        #1; chk("R7 tap17", dout, 1'b1);
        load_cfg(5'd3, 5'd1, 1'b0, 1'b1, 32'h0009_0001);
        #1; chk("R7 tap17^20", dout, 1'b0);
        // R8: zero-run forced one
        load_cfg(5'd3, 5'd1, 1'b0, 1'b1, 32'hFFFF_C000);
        #1; chk("R8 zero run", dout, 1'b1);
        load_cfg(5'd9, 5'd2, 1'b0, 1'b1, 32'hFFFF_FFFF);
        run_bits(400, "R7 R8 qrss");

        // R4: ce low freezes, no valid
        load_cfg(5'd8, 5'd4, 1'b0, 1'b0, 32'h1234_5678);
        run_bits(20, "R4");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ce = 1'b0; #1;
            chk("R4 ce low valid", dvalid, 1'b0);
            chk("R4 ce low dout", dout, m_out(m_sr));
        end
        @(negedge clk); ce = 1'b1;
        run_bits(20, "R4 resume");

        // R3 / R10: disabled load ignored, held load ignored, resume
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); en = 1'b0;
            if (i == 1) begin
                cfg_len = 5'd1; cfg_tap = 5'd0; cfg_rep = 1'b1; cfg_seed = 32'h0;
                load = 1'b1;
            end
            #1; chk("R10 disabled silent", dvalid, 1'b0);
        end
        @(negedge clk); en = 1'b1; #1;
        chk("R10 resume gap", dvalid, 1'b0);
        @(negedge clk);
        run_bits(30, "R3 old pattern kept");
        @(negedge clk); load = 1'b0; #1;
        chk("R3 continue", dout, m_out(m_sr));
        m_sr = {m_sr[30:0], m_feed(m_sr)};
        @(negedge clk);
        run_bits(20, "R3 after release");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule